// File: doc/BRIEF.md
# Bitstream-to-PCM Decimation Filter

This block turns the one-bit output of two sigma-delta modulators (left and right) into one signed PCM word per channel per output frame. It applies a single linear-phase FIR stage directly to the bitstream and reduces the rate by `DECIM` (64 by default) in one step. Each one-bit input sample counts as +1 or -1, so every tap is a coefficient added or subtracted, and no multiplier is needed. The coefficients are symmetric, so only the outer half plus the centre tap is supplied.

The block runs on a master clock at 256 times the output word rate. A modulator-bit strobe arrives every fourth clock and shifts one bit per channel into a history of `NTAPS` bits. When the strobe that closes a frame arrives, the history is frozen into a snapshot. A bank of `LANES` pair adders then walks the folded snapshot, one group of taps per clock, well inside the 256-clock frame. The sum is rounded, saturated and presented on both words with a one-clock valid pulse.

Top module: `bitstream_decim_fir`

## Requirements
- R1: While reset is low and in the first cycle after it, `pcm_vld` is 0 and `pcm_l` and `pcm_r` are 0.
- R2: At a frame close, each channel's pre-rounding sum is y = Σ c_k·s_k over taps k = 0..NTAPS-1. Tap 0 is the bit taken with the closing strobe, tap k is the bit taken k strobes earlier, and s = +1 for a bit of 1 and -1 for a bit of 0. c_k is the signed slice `COEFS[k*COEF_W +: COEF_W]` for k ≤ (NTAPS-1)/2, and c_k = c_{NTAPS-1-k} above the centre.
- R3: The left and right channels keep separate histories, and each word depends only on its own channel's bits.
- R4: Strobes are counted from reset. Strobe number DECIM, 2·DECIM, 3·DECIM and so on each close a frame.
- R5: For each primed frame close, `pcm_vld` is high for exactly one clock, STEPS+1 clocks after the clock edge that took the closing strobe. STEPS = ceil(((NTAPS-1)/2)/LANES). The next close never lands before the previous result is out.
- R6: A frame closed before NTAPS strobes have been taken since reset produces no pulse, and the words keep their value.
- R7: Rounding adds 2^(DROP-1) and then shifts arithmetically right by DROP, so exact halves go toward +infinity.
- R8: The rounded value is clamped to the range [-2^(OUT_W-1), 2^(OUT_W-1)-1].
- R9: `pcm_l` and `pcm_r` change only in the cycle in which `pcm_vld` is high.
- R10: `bit_l` and `bit_r` have no effect in cycles where `bit_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 256 times the word rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-clock strobe marking a new modulator bit |
| bit_l | input | 1 | Left modulator bit |
| bit_r | input | 1 | Right modulator bit |
| pcm_l | output | OUT_W | Left PCM word, two's complement |
| pcm_r | output | OUT_W | Right PCM word, two's complement |
| pcm_vld | output | 1 | One-clock pulse when new words are presented |

## Verification
The bench builds the block with 7 taps, decimation by 4, 2 lanes, 8-bit coefficients 40/30/21/12, DROP = 2 and 6-bit output. These values make STEPS equal to 2, with the last lane of the final step landing past the centre, so the padding path is exercised. Frames are short enough that the priming rule and frame counting show up within a few strobes. The coefficient set produces exact halves and sums just inside and just beyond both saturation limits, so rounding and clamping can be checked against hand-computed words. Two long pseudo-random streams with different strobe spacing, and with junk on the bit inputs between strobes, are compared frame by frame against a model built from the requirements.

// File: rtl/bitstream_decim_fir.sv
module bitstream_decim_fir #(
  parameter int NTAPS = 4095,
  parameter int DECIM = 64,
  parameter int LANES = 16,
  parameter int COEF_W = 20,
  parameter int OUT_W = 18,
  parameter int DROP = 0,
  parameter logic [COEF_W*((NTAPS+1)/2)-1:0] COEFS =
    {((NTAPS+1)/2){{{(COEF_W-1){1'b0}}, 1'b1}}}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_l,
  input  logic bit_r,
  output logic signed [OUT_W-1:0] pcm_l,
  output logic signed [OUT_W-1:0] pcm_r,
  output logic pcm_vld
);
  localparam int MID = (NTAPS - 1) / 2;
  localparam int STEPS = (MID + LANES - 1) / LANES;
  localparam int PADW = STEPS * LANES;
  localparam int ACC_A = COEF_W + $clog2(NTAPS) + 2;
  localparam int ACC_W = (ACC_A > OUT_W + DROP + 1) ? ACC_A : OUT_W + DROP + 1;
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int FILL_W = $clog2(NTAPS + 1);
  localparam int ST_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic signed [ACC_W-1:0] RND = ACC_W'((1 <<< DROP) >> 1);
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = -OUT_MAX - 1;

  logic [NTAPS-1:0] hist_l, hist_r, nx_l, nx_r;
  logic [PADW-1:0] near_l, near_r, far_l, far_r;
  logic [PH_W-1:0] phase;
  logic [FILL_W-1:0] fill;
  logic [ST_W-1:0] step;
  logic busy, done, primed, close;
  logic signed [ACC_W-1:0] acc_l, acc_r, add_l, add_r;

  function automatic logic signed [ACC_W-1:0] coef(input int k);
    return ACC_W'($signed(COEFS[k*COEF_W +: COEF_W]));
  endfunction

  function automatic logic signed [ACC_W-1:0] pair_term(input logic a, input logic b,
                                                        input logic signed [ACC_W-1:0] c);
    if (a && b) return c <<< 1;
    if (!a && !b) return -(c <<< 1);
    return '0;
  endfunction

  function automatic logic [PADW-1:0] near_half(input logic [NTAPS-1:0] h);
    near_half = '0;
    for (int k = 0; k < MID; k++) near_half[k] = h[k];
  endfunction

  function automatic logic [PADW-1:0] far_half(input logic [NTAPS-1:0] h);
    far_half = '0;
    for (int k = 0; k < MID; k++) far_half[k] = h[NTAPS-1-k];
  endfunction

  function automatic logic signed [ACC_W-1:0] centre(input logic [NTAPS-1:0] h);
    return h[MID] ? coef(MID) : -coef(MID);
  endfunction

  function automatic logic signed [OUT_W-1:0] finish_word(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] r;
    r = (a + RND) >>> DROP;
    if (r > OUT_MAX) return OUT_MAX[OUT_W-1:0];
    if (r < OUT_MIN) return OUT_MIN[OUT_W-1:0];
    return r[OUT_W-1:0];
  endfunction

  assign nx_l = {hist_l[NTAPS-2:0], bit_l};
  assign nx_r = {hist_r[NTAPS-2:0], bit_r};
  assign close = bit_stb && (phase == PH_W'(DECIM - 1));

  always_comb begin
    add_l = '0;
    add_r = '0;
    for (int l = 0; l < LANES; l++) begin
      if (int'(step) * LANES + l < MID) begin
        add_l = add_l + pair_term(near_l[l], far_l[l], coef(int'(step) * LANES + l));
        add_r = add_r + pair_term(near_r[l], far_r[l], coef(int'(step) * LANES + l));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_l <= '0;
      hist_r <= '0;
      phase <= '0;
      fill <= '0;
      near_l <= '0;
      near_r <= '0;
      far_l <= '0;
      far_r <= '0;
      acc_l <= '0;
      acc_r <= '0;
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      primed <= 1'b0;
      pcm_l <= '0;
      pcm_r <= '0;
      pcm_vld <= 1'b0;
    end else begin
      done <= 1'b0;
      pcm_vld <= 1'b0;
      if (bit_stb) begin
        hist_l <= nx_l;
        hist_r <= nx_r;
        phase <= close ? '0 : phase + 1'b1;
        if (fill != FILL_W'(NTAPS)) fill <= fill + 1'b1;
      end
      if (close) begin
        near_l <= near_half(nx_l);
        near_r <= near_half(nx_r);
        far_l <= far_half(nx_l);
        far_r <= far_half(nx_r);
        acc_l <= centre(nx_l);
        acc_r <= centre(nx_r);
        step <= '0;
        busy <= 1'b1;
        primed <= (fill >= FILL_W'(NTAPS - 1));
      end else if (busy) begin
        acc_l <= acc_l + add_l;
        acc_r <= acc_r + add_r;
        near_l <= near_l >> LANES;
        near_r <= near_r >> LANES;
        far_l <= far_l >> LANES;
        far_r <= far_r >> LANES;
        step <= step + 1'b1;
        if (step == ST_W'(STEPS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      if (done && primed) begin
        pcm_l <= finish_word(acc_l);
        pcm_r <= finish_word(acc_r);
        pcm_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitstream_decim_fir_chk.sv
module bitstream_decim_fir_chk #(
  parameter int NTAPS = 4095,
  parameter int DECIM = 64,
  parameter int LANES = 16,
  parameter int OUT_W = 18
) (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic pcm_vld,
  input logic signed [OUT_W-1:0] pcm_l,
  input logic signed [OUT_W-1:0] pcm_r
);
  localparam int MID = (NTAPS - 1) / 2;
  localparam int STEPS = (MID + LANES - 1) / LANES;
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int N_W = $clog2(NTAPS + 1);
  localparam int SC_W = $clog2(STEPS + 3);

  logic [PH_W-1:0] ph;
  logic [N_W-1:0] nstb;
  logic [SC_W-1:0] since;
  logic frame_end;

  assign frame_end = bit_stb && (ph == PH_W'(DECIM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
      nstb <= '0;
      since <= '1;
    end else begin
      if (bit_stb) begin
        ph <= frame_end ? '0 : ph + 1'b1;
        if (nstb != N_W'(NTAPS)) nstb <= nstb + 1'b1;
      end
      if (frame_end) since <= '0;
      else if (since != '1) since <= since + 1'b1;
    end
  end

  assert_vld_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_vld |=> !pcm_vld);

  assert_vld_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_vld |-> since == SC_W'(STEPS + 1));

  assert_frame_fits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> since > SC_W'(STEPS));

  assert_primed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_vld |-> nstb >= N_W'(NTAPS));

  assert_words_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_vld |-> ($stable(pcm_l) && $stable(pcm_r)));
endmodule

bind bitstream_decim_fir bitstream_decim_fir_chk #(
  .NTAPS(NTAPS), .DECIM(DECIM), .LANES(LANES), .OUT_W(OUT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .pcm_vld(pcm_vld),
  .pcm_l(pcm_l), .pcm_r(pcm_r)
);

// File: tb/bitstream_decim_fir_tb_top.sv
`timescale 1ns/1ps
module bitstream_decim_fir_tb_top;
  localparam int NT = 7;
  localparam int DC = 4;
  localparam int LN = 2;
  localparam int CW = 8;
  localparam int OW = 6;
  localparam int DR = 2;
  localparam int LAT = 4;
  localparam logic [CW*4-1:0] CF = {8'd12, 8'd21, 8'd30, 8'd40};
  localparam int CK [NT] = '{40, 30, 21, 12, 21, 30, 40};

  typedef struct packed {
    logic [6:0] wl;
    logic [6:0] wr;
    logic signed [7:0] el;
    logic signed [7:0] er;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'b1111111, 7'b0000000, 8'sd31, -8'sd32},
    '{7'b1010101, 7'b0101010, 8'sd13, -8'sd12},
    '{7'b1110000, 7'b0001111, -8'sd3, 8'sd3},
    '{7'b0000010, 7'b0111110, -8'sd32, 8'sd9},
    '{7'b0111111, 7'b1110011, 8'sd29, 8'sd31},
    '{7'b0011000, 7'b0000001, -8'sd32, -8'sd28}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0;
  logic bit_l = 1'b0;
  logic bit_r = 1'b0;
  logic signed [OW-1:0] pcm_l, pcm_r;
  logic pcm_vld;

  always #4 clk = ~clk;

  bitstream_decim_fir #(
    .NTAPS(NT), .DECIM(DC), .LANES(LN), .COEF_W(CW), .OUT_W(OW), .DROP(DR), .COEFS(CF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_l(bit_l), .bit_r(bit_r),
    .pcm_l(pcm_l), .pcm_r(pcm_r), .pcm_vld(pcm_vld)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int nstb = 0;
  int due = 0;
  bit pend = 0;
  int exp_l, exp_r, hold_l, hold_r;
  logic [NT-1:0] bhl, bhr;
  logic [15:0] lf = 16'hACE1;

  function automatic int model(input logic [NT-1:0] h);
    int y = 0;
    int r;
    for (int k = 0; k < NT; k++) y += h[k] ? CK[k] : -CK[k];
    r = (y + 2) >>> DR;
    if (r > 31) r = 31;
    if (r < -32) r = -32;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (!rst_n) begin
      chk(pcm_vld == 1'b0, "R1 valid low in reset", int'(pcm_vld), 0);
      chk(pcm_l == 0 && pcm_r == 0, "R1 words zero in reset", int'(pcm_l), 0);
    end else if (pend && cyc == due) begin
      chk(pcm_vld == 1'b1, "R4 R5 pulse in its slot", int'(pcm_vld), 1);
      chk(int'(pcm_l) == exp_l, "R2 left word", int'(pcm_l), exp_l);
      chk(int'(pcm_r) == exp_r, "R3 right word", int'(pcm_r), exp_r);
      hold_l = int'(pcm_l);
      hold_r = int'(pcm_r);
      pend = 0;
    end else begin
      chk(pcm_vld == 1'b0, "R5 R6 no pulse outside slot", int'(pcm_vld), 0);
      chk(int'(pcm_l) == hold_l, "R9 left word holds", int'(pcm_l), hold_l);
      chk(int'(pcm_r) == hold_r, "R9 right word holds", int'(pcm_r), hold_r);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bit_stb = 1'b0;
    pend = 0;
    nstb = 0;
    bhl = '0;
    bhr = '0;
    hold_l = 0;
    hold_r = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic push(input logic bl, input logic br, input int gap);
    bit_stb = 1'b1;
    bit_l = bl;
    bit_r = br;
    nstb++;
    bhl = {bhl[NT-2:0], bl};
    bhr = {bhr[NT-2:0], br};
    if (nstb % DC == 0 && nstb >= NT) begin
      pend = 1;
      due = cyc + LAT;
      exp_l = model(bhl);
      exp_r = model(bhr);
    end
    tick();
    bit_stb = 1'b0;
    for (int g = 1; g < gap; g++) begin
      next_lf();
      bit_l = lf[0];
      bit_r = lf[5];
      tick();
    end
    next_lf();
    bit_l = lf[3];
    bit_r = lf[9];
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) tick();
    for (int v = 0; v < 6; v++) begin
      do_reset();
      push(1'b1, 1'b0, 2);
      for (int k = NT - 1; k >= 0; k--) push(VECS[v].wl[k], VECS[v].wr[k], 2);
      repeat (3) tick();
      chk(hold_l == int'(VECS[v].el), "R7 R8 table left", hold_l, int'(VECS[v].el));
      chk(hold_r == int'(VECS[v].er), "R7 R8 table right", hold_r, int'(VECS[v].er));
      chk(!pend, "R5 table pulse seen", int'(pend), 0);
    end

    do_reset();
    for (int i = 0; i < 200; i++) begin
      next_lf();
      push(lf[2], lf[11], 2);
    end
    repeat (6) tick();
    chk(!pend, "R10 stream pulse seen", int'(pend), 0);

    do_reset();
    for (int i = 0; i < 150; i++) begin
      next_lf();
      push(lf[7], lf[1] ^ lf[4], 3);
    end
    repeat (6) tick();
    chk(!pend, "R4 wide-gap pulse seen", int'(pend), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule